// File: doc/BRIEF.md
# Four-Word Program Command Sequencer

This block decodes bus-write commands for a flash-style memory model and runs a command that programs four words. A setup write is followed by four address/data writes. The fifth write hands the collected words to an internal program engine. The engine waits a fixed latency and then writes each word into a word-array stub. A programming write can only clear bits.

While the engine is busy, every read returns the status word. The only commands accepted in that time are the four read-mode commands. Everything else, including another setup and the status clear, is dropped. The operation has no suspend and no second concurrent operation. Pulling the reset low aborts the work in progress and leaves the touched cells undefined.

The four addresses must fall inside one aligned group of four words. An address outside the group of the first word rejects the whole command and raises an error flag in the status word.

Top module: `quadword_prog_seq`

## Requirements
- R1: After a synchronous reset (rst_n low on a clock edge) the read mode is array. An erased cell reads 0xFFFF. After command 0x70 the status word reads 0x0080.
- R2: A command is the low 8 bits of wr_data in a write cycle. Setup code 0x55 in the idle state makes the next four writes the word address/data pairs. The fourth of them, which is the fifth write, starts the engine. A read in the very next cycle shows status bit 7 at 0.
- R3: When the operation completes, each of the four cells holds its old value AND the written data. The words may be given in any order within the group.
- R4: Status bit 7 is 0 while the engine is busy and 1 otherwise. While busy, a read at any address returns the status word. After completion, reads keep returning status until a read-mode command is written.
- R5: While busy, read-mode commands 0xFF (array), 0x70 (status), 0x90 (identifier) and 0x98 (query) are accepted and take effect after completion. Setup 0x55, clear 0x50 and all other codes are ignored.
- R6: A word address whose bits above the low 2 differ from those of the first word rejects the command at that write. No cell changes, status bit 4 is set, the read mode becomes status and the sequencer returns to idle.
- R7: Command 0x50 in the idle state clears status bit 4. Status bits other than 7 and 4 read 0.
- R8: rst_n low while busy aborts the operation. The next reads give array mode with bit 7 at 1, and a new command then runs normally.
- R9: In identifier mode, address 0 reads MFR_ID and address 1 reads DEV_ID. In query mode, addresses 0, 1 and 2 read 0x0051, 0x0052 and 0x0059. Every other address in these modes reads 0.
- R10: In the idle state, an unrecognised code changes nothing. The read mode and the array stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; aborts an operation |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write word address |
| wr_data | input | DATA_W | Bus write data; low byte is the command code |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read data, one cycle after rd_addr |

## Verification
The assertions assume that wr_en is a single-cycle strobe per bus write and that rst_n is held low across at least one clock edge. They also assume that rd_addr is stable from one edge to the next. The stimulus meets this by driving every input one time unit after a rising edge. It holds each write for exactly one edge and polls status before it issues a new command, except in the scenarios that deliberately send commands to a busy engine.

// File: rtl/qwp_pkg.sv
package qwp_pkg;
  localparam int GROUP_WORDS = 4;
  localparam int GROUP_BITS  = $clog2(GROUP_WORDS);

  localparam logic [7:0] C_READ_ARRAY = 8'hFF;
  localparam logic [7:0] C_READ_STAT  = 8'h70;
  localparam logic [7:0] C_READ_IDENT = 8'h90;
  localparam logic [7:0] C_READ_QUERY = 8'h98;
  localparam logic [7:0] C_CLR_STAT   = 8'h50;
  localparam logic [7:0] C_SETUP      = 8'h55;

  localparam int ST_READY_BIT = 7;
  localparam int ST_ERR_BIT   = 4;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT, RM_QUERY} rmode_t;

  function automatic logic is_read_cmd(input logic [7:0] c);
    return (c == C_READ_ARRAY) || (c == C_READ_STAT) ||
           (c == C_READ_IDENT) || (c == C_READ_QUERY);
  endfunction

  function automatic rmode_t mode_of(input logic [7:0] c);
    case (c)
      C_READ_STAT:  return RM_STATUS;
      C_READ_IDENT: return RM_IDENT;
      C_READ_QUERY: return RM_QUERY;
      default:      return RM_ARRAY;
    endcase
  endfunction
endpackage

// File: rtl/qwp_cmd_seq.sv
module qwp_cmd_seq
  import qwp_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [AW-1:0]                     wr_addr,
  input  logic [DW-1:0]                     wr_data,
  input  logic                              eng_done,
  output logic                              busy,
  output logic                              err,
  output rmode_t                            mode,
  output logic                              start,
  output logic [GROUP_WORDS-1:0][AW-1:0]    slot_addr,
  output logic [GROUP_WORDS-1:0][DW-1:0]    slot_data
);
  typedef enum logic [1:0] {S_IDLE, S_GATHER, S_BUSY} st_t;

  localparam int TW = AW - GROUP_BITS;

  st_t                  st_q;
  logic [GROUP_BITS-1:0] cnt_q;
  logic [TW-1:0]        grp_q;
  logic                 err_q;
  logic                 start_q;
  rmode_t               mode_q;
  logic [7:0]           code;
  logic                 grp_miss;

  assign code     = wr_data[7:0];
  assign grp_miss = (cnt_q != '0) && (wr_addr[AW-1:GROUP_BITS] != grp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      grp_q     <= '0;
      err_q     <= 1'b0;
      start_q   <= 1'b0;
      mode_q    <= RM_ARRAY;
      slot_addr <= '0;
      slot_data <= '0;
    end else begin
      start_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (wr_en) begin
            if (is_read_cmd(code)) begin
              mode_q <= mode_of(code);
            end else if (code == C_CLR_STAT) begin
              err_q <= 1'b0;
            end else if (code == C_SETUP) begin
              st_q  <= S_GATHER;
              cnt_q <= '0;
            end
          end
        end
        S_GATHER: begin
          if (wr_en) begin
            if (grp_miss) begin
              err_q  <= 1'b1;
              mode_q <= RM_STATUS;
              st_q   <= S_IDLE;
            end else begin
              slot_addr[cnt_q] <= wr_addr;
              slot_data[cnt_q] <= wr_data;
              if (cnt_q == '0) grp_q <= wr_addr[AW-1:GROUP_BITS];
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == GROUP_BITS'(GROUP_WORDS - 1)) begin
                st_q    <= S_BUSY;
                start_q <= 1'b1;
                mode_q  <= RM_STATUS;
              end
            end
          end
        end
        S_BUSY: begin
          if (wr_en && is_read_cmd(code)) mode_q <= mode_of(code);
          if (eng_done) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy  = (st_q == S_BUSY);
  assign err   = err_q;
  assign mode  = mode_q;
  assign start = start_q;
endmodule

// File: rtl/qwp_prog_engine.sv
module qwp_prog_engine
  import qwp_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int LAT = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [GROUP_WORDS-1:0][AW-1:0] slot_addr,
  input  logic [GROUP_WORDS-1:0][DW-1:0] slot_data,
  output logic                           arr_we,
  output logic [AW-1:0]                  arr_waddr,
  output logic [DW-1:0]                  arr_wdata,
  output logic                           done
);
  localparam int CW = $clog2(LAT + 1) + 1;

  typedef enum logic [1:0] {E_IDLE, E_WAIT, E_WRITE} est_t;

  est_t                  st_q;
  logic [CW-1:0]         wait_q;
  logic [GROUP_BITS-1:0] idx_q;
  logic                  done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      wait_q <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        E_IDLE: begin
          if (start) begin
            st_q   <= E_WAIT;
            wait_q <= CW'(LAT);
            idx_q  <= '0;
          end
        end
        E_WAIT: begin
          if (wait_q == '0) st_q <= E_WRITE;
          else wait_q <= wait_q - 1'b1;
        end
        E_WRITE: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == GROUP_BITS'(GROUP_WORDS - 1)) begin
            st_q   <= E_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign arr_we    = (st_q == E_WRITE);
  assign arr_waddr = slot_addr[idx_q];
  assign arr_wdata = slot_data[idx_q];
  assign done      = done_q;
endmodule

// File: rtl/qwp_word_array.sv
module qwp_word_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= mem[waddr] & wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/qwp_read_port.sv
module qwp_read_port
  import qwp_pkg::*;
#(
  parameter int          AW     = 8,
  parameter int          DW     = 16,
  parameter logic [15:0] MFR_ID = 16'h00A5,
  parameter logic [15:0] DEV_ID = 16'h5A3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  input  logic          busy,
  input  logic          err,
  input  rmode_t        mode,
  input  logic [DW-1:0] arr_q,
  output logic [DW-1:0] rd_data
);
  rmode_t        sel_q;
  logic [DW-1:0] stat_q;
  logic [DW-1:0] info_q;
  logic [DW-1:0] stat_w;
  logic [DW-1:0] info_w;

  always_comb begin
    stat_w               = '0;
    stat_w[ST_READY_BIT] = !busy;
    stat_w[ST_ERR_BIT]   = err;
  end

  always_comb begin
    info_w = '0;
    if (mode == RM_IDENT) begin
      if (rd_addr == AW'(0)) info_w = DW'(MFR_ID);
      else if (rd_addr == AW'(1)) info_w = DW'(DEV_ID);
    end else if (mode == RM_QUERY) begin
      if (rd_addr == AW'(0)) info_w = DW'(16'h0051);
      else if (rd_addr == AW'(1)) info_w = DW'(16'h0052);
      else if (rd_addr == AW'(2)) info_w = DW'(16'h0059);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= RM_ARRAY;
      stat_q <= '0;
      info_q <= '0;
    end else begin
      sel_q  <= busy ? RM_STATUS : mode;
      stat_q <= stat_w;
      info_q <= info_w;
    end
  end

  always_comb begin
    case (sel_q)
      RM_STATUS: rd_data = stat_q;
      RM_IDENT,
      RM_QUERY:  rd_data = info_q;
      default:   rd_data = arr_q;
    endcase
  end
endmodule

// File: rtl/quadword_prog_seq.sv
module quadword_prog_seq
  import qwp_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 16,
  parameter int          PROG_LAT = 6,
  parameter logic [15:0] MFR_ID   = 16'h00A5,
  parameter logic [15:0] DEV_ID   = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic                               seq_busy;
  logic                               seq_err;
  rmode_t                             seq_mode;
  logic                               eng_start;
  logic                               eng_done;
  logic [GROUP_WORDS-1:0][ADDR_W-1:0] slot_addr;
  logic [GROUP_WORDS-1:0][DATA_W-1:0] slot_data;
  logic                               arr_we;
  logic [ADDR_W-1:0]                  arr_waddr;
  logic [DATA_W-1:0]                  arr_wdata;
  logic [DATA_W-1:0]                  arr_q;

  qwp_cmd_seq #(.AW(ADDR_W), .DW(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_done(eng_done), .busy(seq_busy), .err(seq_err),
    .mode(seq_mode), .start(eng_start), .slot_addr(slot_addr),
    .slot_data(slot_data)
  );

  qwp_prog_engine #(.AW(ADDR_W), .DW(DATA_W), .LAT(PROG_LAT)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .slot_addr(slot_addr),
    .slot_data(slot_data), .arr_we(arr_we), .arr_waddr(arr_waddr),
    .arr_wdata(arr_wdata), .done(eng_done)
  );

  qwp_word_array #(.AW(ADDR_W), .DW(DATA_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(rd_addr), .rdata(arr_q)
  );

  qwp_read_port #(.AW(ADDR_W), .DW(DATA_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .busy(seq_busy),
    .err(seq_err), .mode(seq_mode), .arr_q(arr_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/quadword_prog_seq_chk.sv
module quadword_prog_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] rd_data,
  input logic          seq_busy,
  input logic          seq_err,
  input logic          eng_start,
  input logic          eng_done,
  input logic          arr_we
);
  p_write_in_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> seq_busy);

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_done_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !seq_busy);

  p_busy_reads_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> (rd_data[7] == 1'b0 && rd_data[DW-1:8] == '0));

  p_busy_keeps_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> $stable(seq_err));

  p_reject_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> !eng_start);

  p_reset_aborts_r8: assert property (@(posedge clk)
    !rst_n |=> (!seq_busy && !arr_we));
endmodule

bind quadword_prog_seq quadword_prog_seq_chk #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .seq_busy(seq_busy),
  .seq_err(seq_err), .eng_start(eng_start), .eng_done(eng_done),
  .arr_we(arr_we)
);

// File: tb/quadword_prog_seq_bench.sv
`timescale 1ns/1ps
module quadword_prog_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  quadword_prog_seq u_quadword_prog_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %04h expected %04h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    rd_addr = a;
    @(posedge clk); #1;
    v = rd_data;
  endtask

  task automatic wait_ready(input string tag);
    logic [15:0] v;
    for (int i = 0; i < 64; i++) begin
      rd(8'h00, v);
      if (v[7]) return;
    end
    checks++; errors++;
    $display("FAIL %s: ready never seen, got %04h expected bit7 set", tag, v);
  endtask

  task automatic prog(input logic [7:0] a0, a1, a2, a3,
                      input logic [15:0] d0, d1, d2, d3);
    bus_wr(8'h00, 16'h0055);
    bus_wr(a0, d0); bus_wr(a1, d1); bus_wr(a2, d2); bus_wr(a3, d3);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    rd(8'h05, v); check("R1 erased array read", v, 16'hFFFF);
    bus_wr(8'h00, 16'h0070);
    rd(8'h00, v); check("R1 status after reset", v, 16'h0080);
  endtask

  task automatic t_program();
    logic [15:0] v;
    prog(8'h10, 8'h11, 8'h12, 8'h13, 16'h1234, 16'hABCD, 16'h0F0F, 16'h8001);
    rd(8'h10, v); check("R2 busy right after fifth write", v, 16'h0000);
    rd(8'h77, v); check("R4 status at any address", v, 16'h0000);
    wait_ready("R4 completion");
    rd(8'h11, v); check("R4 status kept after done", v, 16'h0080);
    bus_wr(8'h00, 16'h00FF);
    rd(8'h10, v); check("R3 word0", v, 16'h1234);
    rd(8'h11, v); check("R3 word1", v, 16'hABCD);
    rd(8'h13, v); check("R3 word3", v, 16'h8001);
    prog(8'h10, 8'h11, 8'h12, 8'h13, 16'hFF0F, 16'hFFFF, 16'hF0FF, 16'h7FFF);
    wait_ready("R3 second program");
    bus_wr(8'h00, 16'h00FF);
    rd(8'h10, v); check("R3 AND word0", v, 16'h1204);
    rd(8'h12, v); check("R3 AND word2", v, 16'h000F);
    rd(8'h13, v); check("R3 AND word3", v, 16'h0001);
  endtask

  task automatic t_order();
    logic [15:0] v;
    prog(8'h23, 8'h21, 8'h20, 8'h22, 16'h0003, 16'h0001, 16'h0000, 16'h0002);
    wait_ready("R3 order");
    bus_wr(8'h00, 16'h00FF);
    rd(8'h20, v); check("R3 unordered 20", v, 16'h0000);
    rd(8'h23, v); check("R3 unordered 23", v, 16'h0003);
  endtask

  task automatic t_mismatch();
    logic [15:0] v;
    bus_wr(8'h00, 16'h0055);
    bus_wr(8'h30, 16'h0000); bus_wr(8'h31, 16'h0000); bus_wr(8'h35, 16'h0000);
    rd(8'h30, v); check("R6 reject sets error", v, 16'h0090);
    bus_wr(8'h00, 16'h00FF);
    rd(8'h30, v); check("R6 cell 30 untouched", v, 16'hFFFF);
    rd(8'h31, v); check("R6 cell 31 untouched", v, 16'hFFFF);
    bus_wr(8'h00, 16'h0050);
    bus_wr(8'h00, 16'h0070);
    rd(8'h00, v); check("R7 clear status", v, 16'h0080);
  endtask

  task automatic t_busy_filter();
    logic [15:0] v;
    bus_wr(8'h00, 16'h0055);
    bus_wr(8'h30, 16'h0000); bus_wr(8'h38, 16'h0000);
    prog(8'h40, 8'h41, 8'h42, 8'h43, 16'h00AA, 16'h00BB, 16'h00CC, 16'h00DD);
    bus_wr(8'h00, 16'h0055);
    bus_wr(8'h00, 16'h0050);
    bus_wr(8'h00, 16'h0090);
    rd(8'h00, v); check("R5 status while busy", v, 16'h0010);
    wait_ready("R5 completion");
    rd(8'h00, v); check("R5 ident accepted while busy", v, 16'h00A5);
    rd(8'h01, v); check("R9 device id", v, 16'h5A3C);
    rd(8'h07, v); check("R9 ident other address", v, 16'h0000);
    bus_wr(8'h00, 16'h0070);
    rd(8'h00, v); check("R5 clear ignored while busy", v, 16'h0090);
    bus_wr(8'h00, 16'h0050);
    bus_wr(8'h00, 16'h0098);
    rd(8'h00, v); check("R9 query 0", v, 16'h0051);
    rd(8'h01, v); check("R9 query 1", v, 16'h0052);
    rd(8'h02, v); check("R9 query 2", v, 16'h0059);
    rd(8'h03, v); check("R9 query 3", v, 16'h0000);
  endtask

  task automatic t_unknown();
    logic [15:0] v;
    bus_wr(8'h00, 16'h00FF);
    bus_wr(8'h10, 16'h0033);
    rd(8'h10, v); check("R10 unknown code no mode change", v, 16'h1204);
    rd(8'h41, v); check("R10 array still read", v, 16'h00BB);
  endtask

  task automatic t_abort();
    logic [15:0] v;
    prog(8'h50, 8'h51, 8'h52, 8'h53, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    rd(8'h60, v); check("R8 array mode after abort", v, 16'hFFFF);
    bus_wr(8'h00, 16'h0070);
    rd(8'h00, v); check("R8 ready after abort", v, 16'h0080);
    prog(8'h50, 8'h51, 8'h52, 8'h53, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    wait_ready("R8 rerun");
    bus_wr(8'h00, 16'h00FF);
    rd(8'h52, v); check("R8 rerun programs", v, 16'h3333);
  endtask

  initial begin
    #1;
    t_reset();
    t_program();
    t_order();
    t_mismatch();
    t_busy_filter();
    t_unknown();
    t_abort();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule